// File: doc/BRIEF.md
# Programmable Interval Timer with Event Timestamp Capture

This block is a down-counting interval timer paired with a free-running timestamp counter. Software sets a reload value and starts the timer through a small register port. In single-shot mode the timer counts down once, raises a sticky tick flag when it reaches zero, and halts. In repeating mode the timer reloads the same value at every zero. This gives a steady stream of tick flags and a square wave that flips on every reload.

Alongside the timer, a wide timestamp counter advances on every clock from reset. A rising edge on the event input copies the timestamp into a capture register. Software can then read back when the event happened. If a capture replaces a value that has not been read, an overrun bit records the loss.

The interrupt output is the tick flag gated by an enable bit. The register file has six locations:

| Address | Contents |
|---|---|
| 0 | Reload value |
| 1 | Control: bit 0 run, bit 1 repeating mode, bit 2 interrupt enable |
| 2 | Status: bit 0 tick flag, bit 1 capture valid, bit 2 overrun, bit 3 running |
| 3 | Live count |
| 4 onward | Capture, one data word per address, least significant word at address 4 |

Top module: `tick_timer`

## Requirements
- R1: A write to address 1 with bit 0 set, while the timer is stopped, loads the count from the reload value at that clock edge and sets the running state. The count then falls by one on each following clock edge while it is non-zero. A run write while already running does not reload.
- R2: Single-shot mode (control bit 1 = 0) works as follows. With reload N, the tick flag rises on the (N+1)th clock edge after the starting edge. At that same edge the running state (status bit 3) clears and the count stays at 0. No further tick is raised until the timer is started again.
- R3: Repeating mode (control bit 1 = 1) works as follows. Each time the running count is observed at 0, the count is reloaded at the next edge and a tick is raised. Ticks therefore come every N+1 clock edges.
- R4: The square-wave output is 0 after reset. It toggles exactly at each repeating-mode reload, so its half period is N+1 clock edges.
- R5: The tick flag (status bit 0) is sticky and is cleared only by writing 1 to status bit 0. A new tick in the same cycle wins over the clear. The interrupt output equals the tick flag ANDed with control bit 2.
- R6: The timestamp counter is TSW bits wide (64 by default). It is 0 in the first cycle after reset, increments on every clock edge, and wraps to 0.
- R7: When a rising edge of the event input is seen at a clock edge, the timestamp value held before that edge is stored in the capture register and status bit 1 is set. An event held high captures only once. The capture is readable as DW-bit words from address 4 upward.
- R8: A capture while status bit 1 is still set sets the overrun flag (status bit 2). The new value replaces the old one. A read strobe at address 4 clears status bit 1. Writing 1 to status bit 2 clears the overrun flag, and a new overrun in the same cycle wins over the clear.
- R9: After reset, the following are all 0: the reload value, control, status, count, capture and square-wave output.
- R10: A write to address 1 with bit 0 clear stops the timer. The count then holds its value and no tick is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (consumes a capture at address 4) |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| ev_in | input | 1 | External event; rising edge triggers capture |
| irq | output | 1 | Interrupt: tick flag gated by enable |
| sq_out | output | 1 | Square wave from repeating-mode reloads |

## Verification
The bench builds the block with 8-bit data and counter widths and a 16-bit timestamp. This makes a full sweep of single-shot reload values 0 to 15 and repeating-mode periods 0 to 7 affordable. The 16-bit timestamp wraps after 65,536 cycles, so the bench reaches and checks a capture across the wrap instead of relying on the width parameter alone. The two-word capture also exercises the word-split read path and the consume-on-low-word rule for overrun.

// File: rtl/tt_pkg.sv
package tt_pkg;
   // Register addresses
   localparam int ADDR_RELOAD = 0;
   localparam int ADDR_CTRL   = 1;
   localparam int ADDR_STATUS = 2;
   localparam int ADDR_COUNT  = 3;
   localparam int ADDR_CAP    = 4;

   // Control bits
   localparam int CB_RUN = 0;
   localparam int CB_PER = 1;
   localparam int CB_IEN = 2;

   // Status bits
   localparam int SB_TICK = 0;
   localparam int SB_CAPV = 1;
   localparam int SB_OVR  = 2;
   localparam int SB_RUN  = 3;

   // Decoded single-cycle strobes from the register port
   typedef struct packed {
      logic start;
      logic stop;
      logic ctl_wr;
      logic clr_tick;
      logic clr_ovr;
      logic cap_rd;
   } tt_strobe_t;
endpackage

// File: rtl/tt_downcounter.sv
module tt_downcounter #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          stop,
   input  logic          periodic,
   input  logic [CW-1:0] reload,
   output logic [CW-1:0] count,
   output logic          running,
   output logic          zero_hit,
   output logic          sq
);
   logic at_zero;

   assign at_zero  = (count == '0);
   assign zero_hit = running & at_zero & ~stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         running <= 1'b0;
         sq      <= 1'b0;
      end else if (start && !running) begin
         count   <= reload;
         running <= 1'b1;
      end else if (stop) begin
         running <= 1'b0;
      end else if (running) begin
         if (at_zero) begin
            if (periodic) begin
               count <= reload;
               sq    <= ~sq;
            end else begin
               running <= 1'b0;
            end
         end else begin
            count <= count - 1'b1;
         end
      end
   end
endmodule

// File: rtl/tt_stamp.sv
module tt_stamp #(
   parameter int TSW = 64
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ev_in,
   input  logic           cap_rd,
   input  logic           clr_ovr,
   output logic [TSW-1:0] ts,
   output logic [TSW-1:0] cap,
   output logic           cap_valid,
   output logic           overrun,
   output logic           ev_rise
);
   logic ev_q;

   assign ev_rise = ev_in & ~ev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q <= 1'b0;
         ts   <= '0;
      end else begin
         ev_q <= ev_in;
         ts   <= ts + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap       <= '0;
         cap_valid <= 1'b0;
         overrun   <= 1'b0;
      end else begin
         if (ev_rise) begin
            cap       <= ts;
            cap_valid <= 1'b1;
         end else if (cap_rd) begin
            cap_valid <= 1'b0;
         end
         if (ev_rise && cap_valid && !cap_rd) begin
            overrun <= 1'b1;
         end else if (clr_ovr) begin
            overrun <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tt_regs.sv
module tt_regs
   import tt_pkg::*;
#(
   parameter int DW  = 32,
   parameter int CW  = 32,
   parameter int TSW = 64,
   parameter int AW  = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic           rd_en,
   input  logic [AW-1:0]  addr,
   input  logic [DW-1:0]  wdata,
   output logic [DW-1:0]  rdata,
   output tt_strobe_t     stb,
   output logic [CW-1:0]  reload,
   output logic           periodic,
   output logic           ien,
   output logic           tick_flag,
   input  logic           zero_hit,
   input  logic [CW-1:0]  count,
   input  logic           running,
   input  logic [TSW-1:0] cap,
   input  logic           cap_valid,
   input  logic           overrun
);
   localparam int CAP_WORDS = TSW / DW;

   logic          sel_ctrl;
   logic          sel_stat;
   logic [DW-1:0] cap_word [CAP_WORDS];
   int            a_int;

   assign a_int    = int'(addr);
   assign sel_ctrl = (a_int == ADDR_CTRL);
   assign sel_stat = (a_int == ADDR_STATUS);

   assign stb.ctl_wr   = wr_en & sel_ctrl;
   assign stb.start    = wr_en & sel_ctrl & wdata[CB_RUN];
   assign stb.stop     = wr_en & sel_ctrl & ~wdata[CB_RUN];
   assign stb.clr_tick = wr_en & sel_stat & wdata[SB_TICK];
   assign stb.clr_ovr  = wr_en & sel_stat & wdata[SB_OVR];
   assign stb.cap_rd   = rd_en & (a_int == ADDR_CAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload   <= '0;
         periodic <= 1'b0;
         ien      <= 1'b0;
      end else if (wr_en) begin
         if (a_int == ADDR_RELOAD) reload <= wdata[CW-1:0];
         if (sel_ctrl) begin
            periodic <= wdata[CB_PER];
            ien      <= wdata[CB_IEN];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    tick_flag <= 1'b0;
      else if (zero_hit)             tick_flag <= 1'b1;
      else if (stb.clr_tick)         tick_flag <= 1'b0;
   end

   for (genvar k = 0; k < CAP_WORDS; k++) begin : g_capw
      assign cap_word[k] = cap[k*DW +: DW];
   end

   always_comb begin
      rdata = '0;
      unique case (a_int)
         ADDR_RELOAD: rdata = DW'(reload);
         ADDR_CTRL:   rdata = DW'({ien, periodic, running});
         ADDR_STATUS: rdata = DW'({running, overrun, cap_valid, tick_flag});
         ADDR_COUNT:  rdata = DW'(count);
         default: begin
            for (int k = 0; k < CAP_WORDS; k++) begin
               if (a_int == ADDR_CAP + k) rdata = cap_word[k];
            end
         end
      endcase
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tt_pkg::*;
#(
   parameter int DW  = 32,
   parameter int CW  = 32,
   parameter int TSW = 64,
   parameter int AW  = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic          ev_in,
   output logic          irq,
   output logic          sq_out
);
   localparam int CAP_WORDS = TSW / DW;

   if (DW < 4) begin : g_bad_dw
      $error("tick_timer: DW must be at least 4");
   end
   if (CW < 1 || CW > DW) begin : g_bad_cw
      $error("tick_timer: CW must lie in 1..DW");
   end
   if (TSW < DW || (TSW % DW) != 0) begin : g_bad_tsw
      $error("tick_timer: TSW must be a multiple of DW");
   end
   if (ADDR_CAP + CAP_WORDS > (1 << AW)) begin : g_bad_aw
      $error("tick_timer: AW too small for the capture words");
   end

   tt_strobe_t     stb;
   logic [CW-1:0]  reload;
   logic [CW-1:0]  cnt;
   logic           periodic;
   logic           ien;
   logic           running;
   logic           zero_hit;
   logic           tick_flag;
   logic [TSW-1:0] ts;
   logic [TSW-1:0] cap;
   logic           cap_valid;
   logic           overrun;
   logic           ev_rise;

   tt_regs #(.DW(DW), .CW(CW), .TSW(TSW), .AW(AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .addr      (addr),
      .wdata     (wdata),
      .rdata     (rdata),
      .stb       (stb),
      .reload    (reload),
      .periodic  (periodic),
      .ien       (ien),
      .tick_flag (tick_flag),
      .zero_hit  (zero_hit),
      .count     (cnt),
      .running   (running),
      .cap       (cap),
      .cap_valid (cap_valid),
      .overrun   (overrun)
   );

   tt_downcounter #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (stb.start),
      .stop     (stb.stop),
      .periodic (periodic),
      .reload   (reload),
      .count    (cnt),
      .running  (running),
      .zero_hit (zero_hit),
      .sq       (sq_out)
   );

   tt_stamp #(.TSW(TSW)) u_stamp (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_in     (ev_in),
      .cap_rd    (stb.cap_rd),
      .clr_ovr   (stb.clr_ovr),
      .ts        (ts),
      .cap       (cap),
      .cap_valid (cap_valid),
      .overrun   (overrun),
      .ev_rise   (ev_rise)
   );

   assign irq = tick_flag & ien;
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
   parameter int CW  = 32,
   parameter int TSW = 64
) (
   input logic           clk,
   input logic           rst_n,
   input logic           ctl_wr,
   input logic           clr_tick,
   input logic           cap_rd,
   input logic [CW-1:0]  count,
   input logic [CW-1:0]  reload,
   input logic           running,
   input logic           periodic,
   input logic           zero_hit,
   input logic           tick_flag,
   input logic           sq_out,
   input logic [TSW-1:0] ts,
   input logic [TSW-1:0] cap,
   input logic           cap_valid,
   input logic           overrun,
   input logic           ev_rise
);
   assert_decrement_R1: assert property (@(posedge clk) disable iff (!rst_n)
      running && count != '0 && !ctl_wr |=> count == CW'($past(count) - 1'b1));

   assert_oneshot_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
      running && !periodic && count == '0 && !ctl_wr |=> !running && tick_flag);

   assert_periodic_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      running && periodic && count == '0 && !ctl_wr |=> running && count == $past(reload));

   assert_square_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(running && periodic && count == '0) |=> $stable(sq_out));

   assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick_flag && !clr_tick |=> tick_flag);

   assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      zero_hit |=> tick_flag);

   assert_stamp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ts == TSW'($past(ts) + 1'b1));

   assert_capture_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rise |=> cap == $past(ts) && cap_valid);

   assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rise && cap_valid && !cap_rd |=> overrun);
endmodule

bind tick_timer tt_checker #(.CW(CW), .TSW(TSW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_wr    (stb.ctl_wr),
   .clr_tick  (stb.clr_tick),
   .cap_rd    (stb.cap_rd),
   .count     (cnt),
   .reload    (reload),
   .running   (running),
   .periodic  (periodic),
   .zero_hit  (zero_hit),
   .tick_flag (tick_flag),
   .sq_out    (sq_out),
   .ts        (ts),
   .cap       (cap),
   .cap_valid (cap_valid),
   .overrun   (overrun),
   .ev_rise   (ev_rise)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
   localparam int DW  = 8;
   localparam int CW  = 8;
   localparam int TSW = 16;
   localparam int AW  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          ev_in = 1'b0;
   logic          irq;
   logic          sq_out;

   int n_chk = 0;
   int n_bad = 0;
   longint edges = 0;

   always #10 clk = ~clk;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) edges <= 0;
      else        edges <= edges + 1;

   tick_timer #(.DW(DW), .CW(CW), .TSW(TSW), .AW(AW)) i_tick_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .ev_in(ev_in), .irq(irq), .sq_out(sq_out)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cycle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      addr = AW'(a); wdata = DW'(d); wr_en = 1'b1;
      cycle();
      wr_en = 1'b0;
   endtask

   task automatic peek(input int a, output int d);
      addr = AW'(a);
      #1 d = int'(rdata);
   endtask

   task automatic consume();
      addr = AW'(4); rd_en = 1'b1;
      cycle();
      rd_en = 1'b0;
   endtask

   task automatic read_cap(output int v);
      int lo, hi;
      peek(4, lo);
      peek(5, hi);
      v = (hi << 8) | lo;
   endtask

   task automatic pulse_event(input int hold);
      ev_in = 1'b1;
      repeat (hold) cycle();
      ev_in = 1'b0;
      cycle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int d, v, n, prev, exp_v, c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      for (int a = 0; a < 6; a++) begin
         peek(a, d);
         check($sformatf("R9 reset reg %0d", a), d, 0);
      end
      check("R9 sq_out reset", sq_out, 0);
      check("R9 irq reset", irq, 0);

      // R1 R2 single-shot sweep
      for (int r = 0; r < 16; r++) begin
         wr(0, r);
         wr(1, 5);                        // run + irq enable, single-shot
         peek(3, d);
         check("R1 count loaded", d, r);
         if (r >= 2) begin
            repeat (2) cycle();
            peek(3, d);
            check("R1 count decrements", d, r - 2);
            repeat (r - 2) cycle();
         end else begin
            repeat (r) cycle();
         end
         check("R2 no tick before terminal", irq, 0);
         cycle();
         check("R2 tick after N+1 edges", irq, 1);
         peek(2, d);
         check("R2 running cleared", (d >> 3) & 1, 0);
         wr(2, 1);
         repeat (r + 5) cycle();
         check("R2 only one tick", irq, 0);
         peek(3, d);
         check("R2 count rests at zero", d, 0);
      end

      // R3 R4 R5 R10 repeating sweep
      for (int r = 0; r < 8; r++) begin
         wr(0, r);
         wr(2, 1);
         prev = sq_out;
         wr(1, 3);                        // run + repeating, irq disabled
         for (int k = 0; k < 2; k++) begin
            n = 0;
            do begin cycle(); n++; end while (sq_out == prev && n < 100);
            check("R3 R4 period edges", n, r + 1);
            prev = sq_out;
         end
         peek(2, d);
         check("R5 tick flag set", d & 1, 1);
         check("R5 irq gated off", irq, 0);
         wr(1, 4);                        // stop, enable irq
         check("R5 irq follows enable", irq, 1);
         wr(2, 1);
         check("R5 W1C clears tick", irq, 0);
         peek(3, c);
         repeat (r + 6) cycle();
         peek(3, d);
         check("R10 count holds when stopped", d, c);
         check("R10 no tick when stopped", irq, 0);
      end

      // R7 capture, held event captures once
      exp_v = int'(edges % 65536);
      pulse_event(3);
      read_cap(v);
      check("R7 capture value", v, exp_v);
      peek(2, d);
      check("R7 valid set", (d >> 1) & 1, 1);
      check("R7 R8 held event no overrun", (d >> 2) & 1, 0);

      // R8 overrun on unread capture
      repeat (4) cycle();
      exp_v = int'(edges % 65536);
      pulse_event(1);
      read_cap(v);
      check("R8 new value replaces old", v, exp_v);
      peek(2, d);
      check("R8 overrun set", (d >> 2) & 1, 1);
      consume();
      peek(2, d);
      check("R8 read clears valid", (d >> 1) & 1, 0);
      check("R8 overrun persists", (d >> 2) & 1, 1);
      wr(2, 4);
      peek(2, d);
      check("R8 W1C clears overrun", (d >> 2) & 1, 0);
      exp_v = int'(edges % 65536);
      pulse_event(1);
      peek(2, d);
      check("R8 capture after read no overrun", (d >> 2) & 1, 0);
      consume();

      // R6 timestamp wrap
      while ((edges % 65536) != 65534) cycle();
      exp_v = int'(edges % 65536);
      pulse_event(1);
      read_cap(v);
      check("R6 capture near top", v, exp_v);
      consume();
      cycle();
      exp_v = int'(edges % 65536);
      pulse_event(1);
      read_cap(v);
      check("R6 capture after wrap", v, exp_v);
      check("R6 wrapped value small", (v < 16) ? 1 : 0, 1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule